// File: doc/BRIEF.md
# Sized Add/Subtract/AND Unit with Status Flags

This unit performs one arithmetic or logical operation per request: add, add-with-carry, subtract, subtract-with-borrow, or bitwise AND. Each request carries operands 8, 16 or 32 bits wide. Along with the result it produces six status bits: carry, auxiliary (nibble) carry, sign, zero, parity and signed overflow. These follow the usual conventions of a little-endian CISC integer core.

A request is presented as an opcode, a size code, a destination operand, a source operand, and the incoming carry and auxiliary-carry flags, all qualified by `in_valid`. One clock later the result and the new flags appear on registered outputs, with `out_valid` high for that cycle. Between requests the outputs keep their last values.

Narrow operations use only the low bits of each operand. The result is returned zero-extended to 32 bits.

Top module: `arith_flag_alu`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`, `result` and all six flag outputs to 0. After a cycle with `in_valid` high, `out_valid` is high in the next cycle. After a cycle with `in_valid` low, `out_valid` is low and `result` and every flag output hold their previous values.
- R2: Opcode 000 gives dst+src and opcode 001 gives dst+src+`cf_in`, both modulo 2^W. W is the selected width. Opcode 000 ignores `cf_in`.
- R3: Opcode 010 gives dst-src and opcode 011 gives dst-src-`cf_in`, both modulo 2^W. Opcode 010 ignores `cf_in`.
- R4: For the add opcodes, CF is the carry out of bit W-1. For the subtract opcodes, CF is 1 exactly when a borrow leaves bit W-1, which is the inverse of the carry out of dst + ~src + (1 - borrow-in).
- R5: For the add opcodes, AF is the carry into bit 4. For the subtract opcodes, AF is the borrow into bit 4.
- R6: For the add opcodes, OF is 1 when dst and src have the same top bit and the result's top bit differs from dst's. For the subtract opcodes, OF is 1 when dst and src have different top bits and the result's top bit differs from dst's.
- R7: Any opcode with bit 2 set (1xx) gives dst AND src, forces CF and OF to 0, and passes `af_in` through to AF unchanged.
- R8: SF is bit W-1 of the result. ZF is 1 when the W-bit result is zero. PF is 1 when the low 8 bits of the result hold an even number of ones.
- R9: Size code 00 selects 8 bits, 01 selects 16 bits, and 10 or 11 selects 32 bits. Operand bits at or above W have no effect, and result bits at or above W are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request qualifier |
| op | input | 3 | Opcode: 000 add, 001 add-with-carry, 010 sub, 011 sub-with-borrow, 1xx AND |
| size | input | 2 | Operand width: 00 byte, 01 halfword, 1x word |
| dst | input | 32 | Destination operand |
| src | input | 32 | Source operand |
| cf_in | input | 1 | Incoming carry flag |
| af_in | input | 1 | Incoming auxiliary-carry flag |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Zero-extended result |
| cf | output | 1 | Carry / borrow |
| af | output | 1 | Nibble carry / borrow |
| sf | output | 1 | Sign |
| zf | output | 1 | Zero |
| pf | output | 1 | Even parity of low byte |
| of | output | 1 | Signed overflow |

## Verification
The bench targets the cases that are easiest to get subtly wrong:
- **Borrow polarity.** 0-1 and 0-0xFF-1 must both report a borrow. A design that returns the raw adder carry on a subtract inverts CF and AF in exactly these cases.
- **Overflow formulas.** 0x7F+1, 0x8000+0x8000 and 0x80000000-0-1 each overflow. A design that swaps the add and subtract overflow rules gets all three wrong.
- **Size handling.** The stimulus puts garbage in the upper operand bits. A design that fails to mask operands, or takes the carry from bit 32 at every size, shows nonzero upper result bits or a missing carry at 8 and 16 bits.
- **AND and the carry input.** The AND cases are run with `cf_in` set, and one add case is also run with it set. These catch an AND that leaks CF or overwrites AF, and a plain add that consumes the carry.

// File: rtl/afa_pkg.sv
package afa_pkg;

    localparam int DATA_W  = 32;
    localparam int LANE_W  = 8;
    localparam int LANES   = DATA_W / LANE_W;
    localparam int NIB_POS = 4;
    localparam int HALF_W  = 16;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_WORD2 = 2'b11
    } size_e;

    typedef struct packed {
        logic logical;   // AND family
        logic subtract;  // SUB / SBB
        logic chain;     // consumes incoming carry
    } op_ctl_t;

    typedef struct packed {
        logic cf;
        logic af;
        logic sf;
        logic zf;
        logic pf;
        logic of;
    } flags_t;

    function automatic op_ctl_t decode_op(input logic [2:0] code);
        op_ctl_t c;
        c.logical  = code[2];
        c.subtract = ~code[2] & code[1];
        c.chain    = ~code[2] & code[0];
        return c;
    endfunction

    function automatic logic msb_at(input logic [DATA_W-1:0] v, input size_e sz);
        logic b;
        case (sz)
            SZ_BYTE: b = v[LANE_W-1];
            SZ_HALF: b = v[HALF_W-1];
            default: b = v[DATA_W-1];
        endcase
        return b;
    endfunction

    function automatic logic even_ones(input logic [LANE_W-1:0] v);
        return ~(^v);
    endfunction

endpackage

// File: rtl/afa_operand_mask.sv
module afa_operand_mask
    import afa_pkg::*;
(
    input  size_e             size_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    output logic [DATA_W-1:0] dst_o,
    output logic [DATA_W-1:0] src_o,
    output logic [DATA_W-1:0] mask_o
);

    logic [LANES-1:0] lane_en;

    // One enable per byte lane: lane 0 always, lane 1 from halfword up,
    // higher lanes only at full width.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_low
            assign lane_en[g] = 1'b1;
        end else if (g == 1) begin : g_mid
            assign lane_en[g] = (size_i != SZ_BYTE);
        end else begin : g_high
            assign lane_en[g] = size_i[1];
        end
        assign mask_o[g*LANE_W +: LANE_W] = {LANE_W{lane_en[g]}};
    end

    assign dst_o = dst_i & mask_o;
    assign src_o = src_i & mask_o;

endmodule

// File: rtl/afa_addsub.sv
module afa_addsub
    import afa_pkg::*;
(
    input  size_e             size_i,
    input  logic              subtract_i,
    input  logic              chain_i,
    input  logic              carry_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o,
    output logic              c4_o
);

    logic [DATA_W-1:0] addend;
    logic              cin_add;
    logic [DATA_W:0]   full;

    // Subtraction runs as dst + ~src + (1 - borrow_in) within the width.
    assign addend  = subtract_i ? (~src_i & mask_i) : src_i;
    assign cin_add = subtract_i ? ~(chain_i & carry_i) : (chain_i & carry_i);
    assign full    = {1'b0, dst_i} + {1'b0, addend} + {{DATA_W{1'b0}}, cin_add};
    assign sum_o   = full[DATA_W-1:0] & mask_i;

    always_comb begin
        case (size_i)
            SZ_BYTE: cout_o = full[LANE_W];
            SZ_HALF: cout_o = full[HALF_W];
            default: cout_o = full[DATA_W];
        endcase
    end

    assign c4_o = dst_i[NIB_POS] ^ addend[NIB_POS] ^ full[NIB_POS];

endmodule

// File: rtl/afa_flag_gen.sv
module afa_flag_gen
    import afa_pkg::*;
(
    input  size_e             size_i,
    input  logic              logical_i,
    input  logic              subtract_i,
    input  logic              af_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              cout_i,
    input  logic              c4_i,
    output flags_t            flags_o
);

    logic res_flip;
    logic ops_differ;

    assign res_flip   = msb_at(res_i ^ dst_i, size_i);
    assign ops_differ = msb_at(dst_i ^ src_i, size_i);

    always_comb begin
        flags_o.sf = msb_at(res_i, size_i);
        flags_o.zf = (res_i == '0);
        flags_o.pf = even_ones(res_i[LANE_W-1:0]);
        if (logical_i) begin
            flags_o.cf = 1'b0;
            flags_o.of = 1'b0;
            flags_o.af = af_i;
        end else if (subtract_i) begin
            flags_o.cf = ~cout_i;
            flags_o.af = ~c4_i;
            flags_o.of = res_flip & ops_differ;
        end else begin
            flags_o.cf = cout_i;
            flags_o.af = c4_i;
            flags_o.of = res_flip & ~ops_differ;
        end
    end

endmodule

// File: rtl/arith_flag_alu.sv
module arith_flag_alu
    import afa_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [2:0]  op,
    input  logic [1:0]  size,
    input  logic [31:0] dst,
    input  logic [31:0] src,
    input  logic        cf_in,
    input  logic        af_in,
    output logic        out_valid,
    output logic [31:0] result,
    output logic        cf,
    output logic        af,
    output logic        sf,
    output logic        zf,
    output logic        pf,
    output logic        of
);

    size_e             sz;
    op_ctl_t           ctl;
    logic [DATA_W-1:0] dst_m, src_m, mask;
    logic [DATA_W-1:0] sum, res_n;
    logic              cout, c4;
    flags_t            flg_n, flg_q;

    assign sz  = size_e'(size);
    assign ctl = decode_op(op);

    afa_operand_mask u_mask (
        .size_i (sz),
        .dst_i  (dst),
        .src_i  (src),
        .dst_o  (dst_m),
        .src_o  (src_m),
        .mask_o (mask)
    );

    afa_addsub u_addsub (
        .size_i     (sz),
        .subtract_i (ctl.subtract),
        .chain_i    (ctl.chain),
        .carry_i    (cf_in),
        .dst_i      (dst_m),
        .src_i      (src_m),
        .mask_i     (mask),
        .sum_o      (sum),
        .cout_o     (cout),
        .c4_o       (c4)
    );

    assign res_n = ctl.logical ? (dst_m & src_m) : sum;

    afa_flag_gen u_flags (
        .size_i     (sz),
        .logical_i  (ctl.logical),
        .subtract_i (ctl.subtract),
        .af_i       (af_in),
        .dst_i      (dst_m),
        .src_i      (src_m),
        .res_i      (res_n),
        .cout_i     (cout),
        .c4_i       (c4),
        .flags_o    (flg_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            flg_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= res_n;
                flg_q  <= flg_n;
            end
        end
    end

    assign cf = flg_q.cf;
    assign af = flg_q.af;
    assign sf = flg_q.sf;
    assign zf = flg_q.zf;
    assign pf = flg_q.pf;
    assign of = flg_q.of;

    a_r1_strobe: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r1_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));
    a_r7_logic_clears: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op[2]) |=> (!cf && !of));
    a_r7_af_kept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op[2]) |=> (af == $past(af_in)));
    a_r8_zero_flag: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (zf == (result == 32'd0)));
    a_r9_byte_zext: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size == 2'b00) |=> (result[31:8] == 24'd0));

endmodule

// File: tb/arith_flag_alu_tb_top.sv
module arith_flag_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  op;
    logic [1:0]  size;
    logic [31:0] dst, src;
    logic        cf_in, af_in;
    logic        out_valid;
    logic [31:0] result;
    logic        cf, af, sf, zf, pf, of;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    arith_flag_alu dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .size(size),
        .dst(dst), .src(src), .cf_in(cf_in), .af_in(af_in),
        .out_valid(out_valid), .result(result),
        .cf(cf), .af(af), .sf(sf), .zf(zf), .pf(pf), .of(of)
    );

    // {op, size, cf_in, af_in, dst, src, expected result, expected {cf,af,sf,zf,pf,of}}
    localparam int VW = 109;
    localparam int NV = 14;
    localparam logic [VW-1:0] VECS [NV] = '{
        {3'b000, 2'b00, 1'b0, 1'b0, 32'h0000007F, 32'h00000001, 32'h00000080, 6'b011001}, // R2 R6 byte overflow
        {3'b000, 2'b00, 1'b0, 1'b0, 32'hABCD12FF, 32'h55AA0001, 32'h00000000, 6'b110110}, // R4 R9 masked carry
        {3'b001, 2'b01, 1'b1, 1'b0, 32'h0000FFFF, 32'h00000000, 32'h00000000, 6'b110110}, // R2 ADC half
        {3'b001, 2'b10, 1'b1, 1'b0, 32'h7FFFFFFF, 32'h00000000, 32'h80000000, 6'b011011}, // R2 R6 word
        {3'b010, 2'b00, 1'b0, 1'b0, 32'h00000000, 32'h00000001, 32'h000000FF, 6'b111010}, // R3 R4 R5 borrow
        {3'b010, 2'b00, 1'b0, 1'b0, 32'h00000080, 32'h00000001, 32'h0000007F, 6'b010001}, // R6 sub overflow
        {3'b011, 2'b01, 1'b1, 1'b0, 32'h00001234, 32'h00000234, 32'h00000FFF, 6'b010010}, // R3 SBB half
        {3'b010, 2'b10, 1'b1, 1'b1, 32'h00000010, 32'h00000010, 32'h00000000, 6'b000110}, // R3 SUB ignores cf_in
        {3'b100, 2'b00, 1'b1, 1'b1, 32'h123456F0, 32'hFFFFFF3C, 32'h00000030, 6'b010010}, // R7 AND byte
        {3'b100, 2'b10, 1'b1, 1'b0, 32'h80000001, 32'h80000003, 32'h80000001, 6'b001000}, // R7 R8 AND word
        {3'b000, 2'b01, 1'b0, 1'b0, 32'hFFFF8000, 32'h00008000, 32'h00000000, 6'b100111}, // R4 R6 R9 half
        {3'b000, 2'b00, 1'b1, 1'b0, 32'h00000008, 32'h00000008, 32'h00000010, 6'b010000}, // R2 ADD ignores cf_in, R5
        {3'b011, 2'b00, 1'b1, 1'b0, 32'h00000000, 32'h000000FF, 32'h00000000, 6'b110110}, // R3 R4 SBB wrap
        {3'b011, 2'b10, 1'b1, 1'b0, 32'h80000000, 32'h00000000, 32'h7FFFFFFF, 6'b010011}  // R3 R6 SBB word
    };

    function automatic string tag_of(input logic [2:0] o);
        if (o[2])      return "R7";
        else if (o[1]) return "R3";
        else           return "R2";
    endfunction

    task automatic check(input bit ok, input string req, input logic [37:0] act, input logic [37:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] o, input logic [1:0] s, input logic c, input logic a,
                         input logic [31:0] d, input logic [31:0] x);
        @(negedge clk);
        in_valid = 1'b1; op = o; size = s; cf_in = c; af_in = a; dst = d; src = x;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [5:0] flags_now();
        return {cf, af, sf, zf, pf, of};
    endfunction

    initial begin
        rst = 1'b1; in_valid = 1'b0; op = '0; size = '0; dst = '0; src = '0;
        cf_in = 1'b0; af_in = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!out_valid && result == 0 && flags_now() == 0, "R1 reset",
              {out_valid, result, flags_now()}, 38'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VECS[i];
            issue(v[108:106], v[105:104], v[103], v[102], v[101:70], v[69:38]);
            check(out_valid && result == v[37:6], $sformatf("%s result vec %0d", tag_of(v[108:106]), i),
                  {5'd0, out_valid, result}, {5'd0, 1'b1, v[37:6]});
            check(flags_now() == v[5:0], $sformatf("R4/R5/R6/R8 flags vec %0d", i),
                  {32'd0, flags_now()}, {32'd0, v[5:0]});
        end

        // R1: idle cycle drops strobe and holds outputs despite changing inputs
        @(negedge clk);
        dst = 32'h11111111; src = 32'h22222222; op = 3'b000; size = 2'b10;
        @(negedge clk);
        check(!out_valid && result == 32'h7FFFFFFF && flags_now() == 6'b010011, "R1 hold",
              {out_valid, result, flags_now()}, {1'b0, 32'h7FFFFFFF, 6'b010011});

        // R9: size code 11 acts as full width
        issue(3'b000, 2'b11, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h00000001);
        check(result == 32'h0 && flags_now() == 6'b110110, "R9 size 11",
              {result, flags_now()}, {32'h0, 6'b110110});

        // R7: opcode 111 is also AND; af_in passed through
        issue(3'b111, 2'b01, 1'b1, 1'b1, 32'hFFFF0F0F, 32'h0000FFFF);
        check(result == 32'h00000F0F && flags_now() == 6'b010010, "R7 op 111",
              {result, flags_now()}, {32'h00000F0F, 6'b010010});

        // R1: back-to-back requests keep the strobe high each cycle
        @(negedge clk);
        in_valid = 1'b1; op = 3'b000; size = 2'b00; dst = 32'd1; src = 32'd2; cf_in = 1'b0;
        @(negedge clk);
        dst = 32'd3;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && result == 32'd5, "R1 back-to-back",
              {5'd0, out_valid, result}, {5'd0, 1'b1, 32'd5});

        done = 1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule